// File: doc/BRIEF.md
# Page-List Byte Address Walker

This block turns byte requests from a USB host controller's data engine into physical addresses for a buffer spread over up to five 4 KB pages. Software loads three things: a list of five page pointers, a current-page index and a total byte count. Bits 11..0 of the first pointer carry the starting byte offset into whichever page the index selects. After the load, the data engine asks for bursts of up to 64 bytes. For each burst the block returns one byte address per cycle.

When the byte stream runs past the last byte of a 4 KB page and bytes remain, the walker moves to the next pointer in the list and carries on at offset zero. The remaining beats of that burst are flagged as a second address segment. The block reports the live page index, the bytes still owed, a one-cycle completion pulse and a sticky overrun error. The error is raised when the list would have to be extended past its fifth pointer.

The controller has four states. IDLE accepts a load. LOADED waits for a burst request. STREAM issues one address per cycle. FAULT holds the overrun until reset. The transitions are:
- IDLE→LOADED on a valid load.
- IDLE→IDLE with a done pulse on a load with a zero count.
- IDLE→FAULT on a load whose index is above 4.
- LOADED→STREAM on an accepted burst.
- STREAM→LOADED when the burst is spent and bytes remain.
- STREAM→IDLE with a done pulse when the count reaches zero.
- STREAM→FAULT when a page ends on pointer 4 while bytes remain.

Top module: `pgl_addr_gen`

## Requirements
- R1: After a synchronous active-low reset the outputs are as follows: load_ready is 1, addr_valid is 0, cur_page is 0, bytes_left is 0, done is 0 and overrun is 0.
- R2: A load is taken only when load_ready is 1, which is true only in IDLE. A load offered in any other state changes neither bytes_left nor cur_page.
- R3: Each beat's address is formed from two parts. Bits 31..12 come from the pointer that cur_page selects, where pointer k is load_ptrs[32k+31:32k]. Bits 11..0 are the running byte offset, which starts at load_ptrs[11..0] and rises by one per beat. Bits 11..0 of pointers 1 to 4 are ignored.
- R4: A burst is accepted only while req_ready is 1, which is true only in LOADED. The length is clamped to 64, and a length of 0 is ignored. A burst longer than bytes_left is cut to bytes_left. Beats run on consecutive cycles starting the cycle after acceptance, and addr_last marks the final beat.
- R5: After a beat at offset 0xFFF with bytes still owed, cur_page rises by one and the offset becomes 0. addr_split is 1 on every later beat of that burst and 0 on the first beat of the next burst.
- R6: bytes_left falls by one for every beat issued.
- R7: When bytes_left reaches zero, done is 1 for one cycle and the block returns to IDLE. A load with a zero count gives the same pulse in the following cycle.
- R8: If a beat at offset 0xFFF on page 4 leaves bytes owed, overrun is set. A load with an index above 4 also sets overrun. While overrun is set, no further address is issued and load_ready stays 0. Only reset clears it.
- R9: If the final byte of the transfer sits at offset 0xFFF, cur_page is not advanced and no overrun is raised, even on page 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| load_valid | input | 1 | Load request |
| load_ptrs | input | 160 | Five page pointers; pointer k at bits 32k+31..32k |
| load_cpage | input | 3 | Starting page index |
| load_total | input | 15 | Total bytes to transfer |
| load_ready | output | 1 | Block is idle and takes a load |
| req_valid | input | 1 | Burst request |
| req_len | input | 7 | Burst length in bytes |
| req_ready | output | 1 | Block takes a burst |
| addr_valid | output | 1 | Address beat present |
| addr | output | 32 | Physical byte address |
| addr_split | output | 1 | Beat lies in the second segment of a split burst |
| addr_last | output | 1 | Final beat of the burst |
| cur_page | output | 3 | Current page index |
| bytes_left | output | 15 | Bytes still to transfer |
| done | output | 1 | Transfer complete pulse |
| overrun | output | 1 | Sticky page-list overrun |

## Verification
The bench aims at boundary crossings. These include a burst that straddles 0xFFF, a transfer whose last byte lands exactly on 0xFFF of page 4, and a stream that runs off the fifth pointer.

A design that advanced the page index on the final byte would report page 5 or a false overrun. A design that used the reserved low bits of pointers 1 to 4 would emit shifted addresses after a crossing. A design that forgot to clear the split flag would mark the first beat of the next burst.

It also checks several other cases:
- Length clamping to 64.
- A request of length zero being ignored.
- Truncation to the remaining count.
- Loads refused outside IDLE.
- An out-of-range start index.

A wrong design would issue too many beats, hang waiting for bytes, or accept a second descriptor part-way through a transfer.

// File: rtl/pgl_pkg.sv
package pgl_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LOADED = 2'd1,
        ST_STREAM = 2'd2,
        ST_FAULT  = 2'd3
    } pgl_state_t;
endpackage

// File: rtl/pgl_ptr_file.sv
module pgl_ptr_file #(
    parameter int NUM_PAGES = 5,
    parameter int ADDR_W    = 32,
    parameter int PAGE_BITS = 12,
    parameter int IDX_W     = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          ld,
    input  logic [NUM_PAGES*ADDR_W-1:0]   ld_ptrs,
    input  logic [IDX_W-1:0]              sel,
    output logic [ADDR_W-PAGE_BITS-1:0]   base
);
    localparam int BASE_W = ADDR_W - PAGE_BITS;

    logic [BASE_W-1:0] page_base [NUM_PAGES];

    // Only the page-frame bits are kept; the low bits of every entry are
    // never stored, so reserved fields cannot leak into an address.
    for (genvar g = 0; g < NUM_PAGES; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                page_base[g] <= '0;
            end else if (ld) begin
                page_base[g] <= ld_ptrs[g*ADDR_W+PAGE_BITS +: BASE_W];
            end
        end
    end

    always_comb begin
        base = '0;
        for (int k = 0; k < NUM_PAGES; k++) begin
            if (sel == IDX_W'(k)) begin
                base = page_base[k];
            end
        end
    end
endmodule

// File: rtl/pgl_cursor.sv
module pgl_cursor #(
    parameter int NUM_PAGES = 5,
    parameter int PAGE_BITS = 12,
    parameter int IDX_W     = 3,
    parameter int CNT_W     = 15,
    parameter int LEN_W     = 7,
    parameter int MAX_BURST = 64
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ld,
    input  logic [PAGE_BITS-1:0] ld_offset,
    input  logic [IDX_W-1:0]     ld_cpage,
    input  logic [CNT_W-1:0]     ld_total,
    input  logic                 accept,
    input  logic [LEN_W-1:0]     req_len,
    input  logic                 step,
    input  logic                 advance,
    output logic [PAGE_BITS-1:0] offset,
    output logic [IDX_W-1:0]     cpage,
    output logic [CNT_W-1:0]     count,
    output logic                 seg2,
    output logic                 cnt_last,
    output logic                 beats_last,
    output logic                 page_end,
    output logic                 page_top
);
    localparam int BEAT_W = $clog2(MAX_BURST + 1);
    localparam logic [PAGE_BITS-1:0] OFF_MAX = {PAGE_BITS{1'b1}};

    logic [BEAT_W-1:0] beats;
    logic [CNT_W-1:0]  len_clamped;
    logic [CNT_W-1:0]  burst_n;

    always_comb begin
        if (CNT_W'(req_len) > CNT_W'(MAX_BURST)) begin
            len_clamped = CNT_W'(MAX_BURST);
        end else begin
            len_clamped = CNT_W'(req_len);
        end
        burst_n = (len_clamped > count) ? count : len_clamped;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            offset <= '0;
            cpage  <= '0;
            count  <= '0;
            beats  <= '0;
            seg2   <= 1'b0;
        end else if (ld) begin
            offset <= ld_offset;
            cpage  <= ld_cpage;
            count  <= ld_total;
            beats  <= '0;
            seg2   <= 1'b0;
        end else if (accept) begin
            beats <= BEAT_W'(burst_n);
            seg2  <= 1'b0;
        end else if (step) begin
            count <= count - CNT_W'(1);
            beats <= beats - BEAT_W'(1);
            if (advance) begin
                cpage  <= cpage + IDX_W'(1);
                offset <= '0;
                seg2   <= (beats != BEAT_W'(1));
            end else begin
                offset <= offset + PAGE_BITS'(1);
            end
        end
    end

    assign cnt_last   = (count == CNT_W'(1));
    assign beats_last = (beats == BEAT_W'(1));
    assign page_end   = (offset == OFF_MAX);
    assign page_top   = (cpage >= IDX_W'(NUM_PAGES - 1));

    assert_beats_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        beats <= BEAT_W'(MAX_BURST));
endmodule

// File: rtl/pgl_fsm.sv
module pgl_fsm
    import pgl_pkg::*;
#(
    parameter int NUM_PAGES = 5,
    parameter int IDX_W     = 3,
    parameter int CNT_W     = 15,
    parameter int LEN_W     = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_valid,
    input  logic [IDX_W-1:0] load_cpage,
    input  logic [CNT_W-1:0] load_total,
    input  logic             req_valid,
    input  logic [LEN_W-1:0] req_len,
    input  logic             cnt_last,
    input  logic             beats_last,
    input  logic             page_end,
    input  logic             page_top,
    output logic             ld,
    output logic             accept,
    output logic             step,
    output logic             advance,
    output logic             load_ready,
    output logic             req_ready,
    output logic             addr_valid,
    output logic             done,
    output logic             overrun
);
    pgl_state_t state, state_nx;
    logic       cpage_bad;
    logic       done_nx;

    assign cpage_bad = (load_cpage > IDX_W'(NUM_PAGES - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            done  <= 1'b0;
        end else begin
            state <= state_nx;
            done  <= done_nx;
        end
    end

    always_comb begin
        state_nx = state;
        done_nx  = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (load_valid) begin
                    if (cpage_bad) begin
                        state_nx = ST_FAULT;
                    end else if (load_total == '0) begin
                        done_nx = 1'b1;
                    end else begin
                        state_nx = ST_LOADED;
                    end
                end
            end
            ST_LOADED: begin
                if (req_valid && (req_len != '0)) begin
                    state_nx = ST_STREAM;
                end
            end
            ST_STREAM: begin
                if (cnt_last) begin
                    state_nx = ST_IDLE;
                    done_nx  = 1'b1;
                end else if (page_end && page_top) begin
                    state_nx = ST_FAULT;
                end else if (beats_last) begin
                    state_nx = ST_LOADED;
                end
            end
            ST_FAULT: begin
                state_nx = ST_FAULT;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        load_ready = (state == ST_IDLE);
        req_ready  = (state == ST_LOADED);
        addr_valid = (state == ST_STREAM);
        overrun    = (state == ST_FAULT);
        ld         = load_ready && load_valid;
        accept     = req_ready && req_valid && (req_len != '0);
        step       = addr_valid;
        advance    = addr_valid && page_end && !cnt_last && !page_top;
    end

    assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> load_ready);
    assert_overrun_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);
    assert_no_addr_in_fault_R8: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |-> (!addr_valid && !load_ready));
endmodule

// File: rtl/pgl_addr_gen.sv
module pgl_addr_gen #(
    parameter int NUM_PAGES = 5,
    parameter int ADDR_W    = 32,
    parameter int PAGE_BITS = 12,
    parameter int IDX_W     = 3,
    parameter int CNT_W     = 15,
    parameter int LEN_W     = 7,
    parameter int MAX_BURST = 64
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        load_valid,
    input  logic [NUM_PAGES*ADDR_W-1:0] load_ptrs,
    input  logic [IDX_W-1:0]            load_cpage,
    input  logic [CNT_W-1:0]            load_total,
    output logic                        load_ready,
    input  logic                        req_valid,
    input  logic [LEN_W-1:0]            req_len,
    output logic                        req_ready,
    output logic                        addr_valid,
    output logic [ADDR_W-1:0]           addr,
    output logic                        addr_split,
    output logic                        addr_last,
    output logic [IDX_W-1:0]            cur_page,
    output logic [CNT_W-1:0]            bytes_left,
    output logic                        done,
    output logic                        overrun
);
    localparam int BASE_W = ADDR_W - PAGE_BITS;

    logic                 ld, accept, step, advance;
    logic                 cnt_last, beats_last, page_end, page_top, seg2;
    logic [PAGE_BITS-1:0] offset;
    logic [BASE_W-1:0]    base;

    pgl_fsm #(
        .NUM_PAGES(NUM_PAGES), .IDX_W(IDX_W), .CNT_W(CNT_W), .LEN_W(LEN_W)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .load_valid(load_valid), .load_cpage(load_cpage), .load_total(load_total),
        .req_valid(req_valid), .req_len(req_len),
        .cnt_last(cnt_last), .beats_last(beats_last),
        .page_end(page_end), .page_top(page_top),
        .ld(ld), .accept(accept), .step(step), .advance(advance),
        .load_ready(load_ready), .req_ready(req_ready), .addr_valid(addr_valid),
        .done(done), .overrun(overrun)
    );

    pgl_cursor #(
        .NUM_PAGES(NUM_PAGES), .PAGE_BITS(PAGE_BITS), .IDX_W(IDX_W),
        .CNT_W(CNT_W), .LEN_W(LEN_W), .MAX_BURST(MAX_BURST)
    ) u_cursor (
        .clk(clk), .rst_n(rst_n),
        .ld(ld), .ld_offset(load_ptrs[PAGE_BITS-1:0]),
        .ld_cpage(load_cpage), .ld_total(load_total),
        .accept(accept), .req_len(req_len), .step(step), .advance(advance),
        .offset(offset), .cpage(cur_page), .count(bytes_left), .seg2(seg2),
        .cnt_last(cnt_last), .beats_last(beats_last),
        .page_end(page_end), .page_top(page_top)
    );

    pgl_ptr_file #(
        .NUM_PAGES(NUM_PAGES), .ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .IDX_W(IDX_W)
    ) u_ptrs (
        .clk(clk), .rst_n(rst_n), .ld(ld), .ld_ptrs(load_ptrs),
        .sel(cur_page), .base(base)
    );

    assign addr       = {base, offset};
    assign addr_split = addr_valid && seg2;
    assign addr_last  = addr_valid && beats_last;

    assert_bytes_left_R6: assert property (@(posedge clk) disable iff (!rst_n)
        addr_valid |=> (bytes_left == $past(bytes_left) - CNT_W'(1)));
    assert_split_at_page_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_split && !$past(addr_split) && $past(addr_valid))
            |-> (addr[PAGE_BITS-1:0] == '0));
endmodule

// File: tb/sim_pgl_addr_gen.sv
module sim_pgl_addr_gen;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         load_valid = 1'b0;
    logic [159:0] load_ptrs = '0;
    logic [2:0]   load_cpage = '0;
    logic [14:0]  load_total = '0;
    logic         load_ready;
    logic         req_valid = 1'b0;
    logic [6:0]   req_len = '0;
    logic         req_ready, addr_valid, addr_split, addr_last, done, overrun;
    logic [31:0]  addr;
    logic [2:0]   cur_page;
    logic [14:0]  bytes_left;

    int checks = 0;
    int errors = 0;

    logic [31:0] m_ptr [5];
    int m_cp, m_off, m_cnt;
    bit m_fault;

    always #2.5 clk = ~clk;

    pgl_addr_gen u0 (.*);

    task automatic chk(string rq, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_cp = 0; m_off = 0; m_cnt = 0; m_fault = 0;
    endtask

    task automatic do_load(logic [31:0] p0, logic [31:0] p1, logic [31:0] p2,
                           logic [31:0] p3, logic [31:0] p4, int cp, int tot);
        bit take;
        @(negedge clk);
        take = load_ready;
        load_ptrs  = {p4, p3, p2, p1, p0};
        load_cpage = 3'(cp);
        load_total = 15'(tot);
        load_valid = 1'b1;
        @(negedge clk);
        load_valid = 1'b0;
        if (take) begin
            m_ptr[0] = p0; m_ptr[1] = p1; m_ptr[2] = p2; m_ptr[3] = p3; m_ptr[4] = p4;
            m_cp = cp; m_off = int'(p0[11:0]); m_cnt = tot;
            if (cp > 4) m_fault = 1;
        end
    endtask

    task automatic run_burst(int len, string rq);
        int n;
        bit seg, stop;
        n = (len > 64) ? 64 : len;
        if (n > m_cnt) n = m_cnt;
        seg = 0; stop = (n == 0);
        @(negedge clk);
        req_valid = 1'b1;
        req_len   = 7'(len);
        @(negedge clk);
        req_valid = 1'b0;
        while (!stop) begin
            chk(rq, "addr_valid", addr_valid, 1);
            chk(rq, "addr", addr, {m_ptr[m_cp][31:12], 12'(m_off)});
            chk(rq, "addr_split", addr_split, seg);
            chk(rq, "addr_last", addr_last, n == 1);
            m_cnt--; n--;
            if (m_off == 4095 && m_cnt > 0) begin
                if (m_cp == 4) begin m_fault = 1; stop = 1; end
                else begin m_cp++; m_off = 0; seg = (n > 0); end
            end else begin
                m_off = (m_off + 1) & 4095;
            end
            if (n == 0 || m_cnt == 0) stop = 1;
            @(negedge clk);
        end
        chk(rq, "addr_valid end", addr_valid, 0);
        chk("R7", "done", done, (m_cnt == 0) && !m_fault);
        chk("R6", "bytes_left", bytes_left, m_cnt);
        chk("R5", "cur_page", cur_page, m_cp);
        chk("R8", "overrun", overrun, m_fault);
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1", "load_ready", load_ready, 1);
        chk("R1", "addr_valid", addr_valid, 0);
        chk("R1", "cur_page", cur_page, 0);
        chk("R1", "bytes_left", bytes_left, 0);
        chk("R1", "done", done, 0);
        chk("R1", "overrun", overrun, 0);
    endtask

    task automatic t_simple();
        do_reset();
        do_load(32'h1000_2100, 32'h2000_3000, 32'h0, 32'h0, 32'h0, 0, 40);
        chk("R2", "req_ready", req_ready, 1);
        run_burst(16, "R3");
        chk("R4", "req_ready again", req_ready, 1);
    endtask

    task automatic t_cross();
        do_reset();
        do_load(32'hA000_0FF8, 32'hB000_1ABC, 32'hC000_2FFF, 32'h0, 32'h0, 0, 100);
        run_burst(20, "R5");
        run_burst(5, "R5");
        chk("R3", "page1 base", cur_page, 1);
    endtask

    task automatic t_index();
        do_reset();
        do_load(32'h0000_0123, 32'h1111_1000, 32'h2222_2FFF, 32'h3333_3000, 32'h4444_4000, 2, 30);
        run_burst(30, "R3");
        chk("R7", "load_ready", load_ready, 1);
    endtask

    task automatic t_lengths();
        do_reset();
        do_load(32'h5000_0000, 32'h6000_0000, 32'h0, 32'h0, 32'h0, 0, 200);
        @(negedge clk);
        req_valid = 1'b1; req_len = 7'd0;
        repeat (3) @(negedge clk);
        req_valid = 1'b0;
        chk("R4", "len0 addr_valid", addr_valid, 0);
        chk("R4", "len0 req_ready", req_ready, 1);
        chk("R4", "len0 bytes_left", bytes_left, 200);
        run_burst(100, "R4");
        do_load(32'h7000_0000, 32'h0, 32'h0, 32'h0, 32'h0, 0, 5);
        chk("R2", "load ignored bytes", bytes_left, 136);
        chk("R2", "load ignored page", cur_page, 0);
        run_burst(64, "R4");
        run_burst(90, "R4");
        chk("R7", "done cleared", done, 0);
    endtask

    task automatic t_overrun();
        do_reset();
        do_load(32'h0000_0FFE, 32'h0, 32'h0, 32'h0, 32'h9000_0000, 4, 5);
        run_burst(5, "R8");
        repeat (3) @(negedge clk);
        chk("R8", "held addr_valid", addr_valid, 0);
        chk("R8", "held overrun", overrun, 1);
        do_load(32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 0, 9);
        chk("R8", "load_ready", load_ready, 0);
        chk("R8", "bytes_left held", bytes_left, 3);
        do_reset();
        chk("R8", "reset clears", overrun, 0);
        do_load(32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 5, 9);
        chk("R8", "bad index", overrun, 1);
        chk("R8", "bad index addr_valid", addr_valid, 0);
    endtask

    task automatic t_final_edge();
        do_reset();
        do_load(32'h0000_0FFC, 32'h0, 32'h0, 32'h0, 32'h8000_0000, 4, 4);
        run_burst(8, "R9");
        chk("R9", "no overrun", overrun, 0);
        chk("R9", "page stays", cur_page, 4);
    endtask

    task automatic t_zero();
        do_reset();
        @(negedge clk);
        load_ptrs = '0; load_cpage = 3'd1; load_total = '0; load_valid = 1'b1;
        @(negedge clk);
        load_valid = 1'b0;
        chk("R7", "zero done", done, 1);
        chk("R7", "zero idle", load_ready, 1);
        @(negedge clk);
        chk("R7", "zero pulse", done, 0);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_simple();
                t_cross();
                t_index();
                t_lengths();
                t_overrun();
                t_final_edge();
                t_zero();
            end
            begin
                repeat (20000) @(posedge clk);
                errors++; checks++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule